// File: doc/BRIEF.md
# Write-Path Protocol Monitor for AXI3

This block is a passive observer for one AXI3 port. It watches the handshakes of all five channels and reports rule breaks on the write path. It also runs a few checks on the read path and on reset behaviour. It drives nothing onto the bus. Every ready signal is an input to the monitor, so it applies no back-pressure.

A transfer counts only on a rising clock edge where its valid and ready are both high. A valid held high while ready is low changes no state and is never a violation.

Write addresses are kept in an acceptance-order queue until their first data beat arrives. Open write bursts, beat counts and the counts of addresses and data awaiting a response are held in tables indexed directly by transaction ID. Each detected violation produces a one-cycle `err_valid` pulse on the edge after the offending cycle. That pulse carries a fixed numeric code on `err_code`.

Top module: `axi_wr_protocol_monitor`

## Requirements
- R1: A write beat counts only when `w_valid` and `w_ready` are both high.
  - The first beat of a burst must carry the ID of the oldest accepted address that has not yet started.
  - If it does not, or if no such address exists, code 60160 is reported and the beat is discarded.
- R2: An accepted beat whose 0-based index within its burst is greater than AWLEN reports code 60161.
- R3: An accepted beat with index equal to AWLEN and `w_last` low reports code 60162, and the burst stays open.
- R4: An accepted beat with index below AWLEN and `w_last` high reports code 60164, and the burst closes.
- R5: A first beat that opens a new burst while IL_DEPTH bursts are already open reports code 60165.
- R6: An accepted response for an ID with no counted, unanswered address reports code 60166.
- R7: An accepted response for an ID that has an unanswered address but no completed, unanswered data burst reports code 60167.
- R8: While `rst_n` is low, each channel's valid signal being high reports its own code:
  - AW reports 60168.
  - W reports 60169.
  - B reports 60170.
  - AR reports 60171.
  - R reports 60172.
  - Every table and counter clears while reset is low.
- R9: For a tracked read burst, `r_last` must be high exactly on the beat whose index equals ARLEN. A mismatch reports code 60173.
- R10: An exclusive write address (`aw_excl` high) is checked against the last exclusive read of the same ID.
  - If that read ended with `r_resp` other than 2'b01 (exclusive okay), code 60174 is reported.
  - The reported failure is then consumed.
- R11: While any write burst is open, TIMEOUT consecutive cycles without an accepted beat report code 60175. The idle count then restarts.
- R12: Code 60176 reports either of two table overflows:
  - A write address accepted while the order queue holds AQ_DEPTH entries.
  - A read address accepted for an ID whose read is still tracked.
- R13: `err_valid` is high for one cycle, on the edge after the offending cycle. When several codes fire together, `err_code` carries only the lowest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_id | input | ID_W | Write address ID |
| aw_len | input | LEN_W | Write burst length minus one |
| aw_excl | input | 1 | Write address is exclusive |
| w_valid | input | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_id | input | ID_W | Write data ID |
| w_last | input | 1 | Write data last beat |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | input | ID_W | Write response ID |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_id | input | ID_W | Read address ID |
| ar_len | input | LEN_W | Read burst length minus one |
| ar_excl | input | 1 | Read address is exclusive |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | input | ID_W | Read data ID |
| r_last | input | 1 | Read data last beat |
| r_resp | input | 2 | Read response, 2'b01 meaning exclusive okay |
| err_valid | output | 1 | One-cycle violation strobe |
| err_code | output | 17 | Code of the lowest violation in that cycle |

## Verification
The bench builds the monitor with the following values:
- AQ_DEPTH = 4, so the fifth outstanding write address overflows the order queue.
- IL_DEPTH = 2, so a third concurrently open burst trips the interleave limit.
- TIMEOUT = 16, so the stall boundary is probed one cycle short and exactly on time.

ID_W = 4 and LEN_W = 4 keep full ID tables while allowing bursts long enough to cover early, missing and overrun last beats.

// File: rtl/axi_wmon_pkg.sv
package axi_wmon_pkg;
  localparam int CODE_W    = 17;
  localparam int CODE_BASE = 60160;
  localparam int NUM_EV    = 17;
  // bit position = code - CODE_BASE
  localparam int EV_ORDER      = 0;
  localparam int EV_OVERRUN    = 1;
  localparam int EV_NOLAST     = 2;
  localparam int EV_EARLYLAST  = 4;
  localparam int EV_INTERLEAVE = 5;
  localparam int EV_B_NOADDR   = 6;
  localparam int EV_B_NODATA   = 7;
  localparam int EV_RST_AW     = 8;
  localparam int EV_RST_W      = 9;
  localparam int EV_RST_B      = 10;
  localparam int EV_RST_AR     = 11;
  localparam int EV_RST_R      = 12;
  localparam int EV_RLAST      = 13;
  localparam int EV_EXCL       = 14;
  localparam int EV_TIMEOUT    = 15;
  localparam int EV_OVERFLOW   = 16;
  localparam logic [1:0] RESP_EXOKAY = 2'b01;
endpackage

// File: rtl/axi_wmon_addr_queue.sv
module axi_wmon_addr_queue #(
  parameter int ID_W  = 4,
  parameter int LEN_W = 4,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [ID_W-1:0]  push_id,
  input  logic [LEN_W-1:0] push_len,
  input  logic             pop,
  output logic             full,
  output logic             empty,
  output logic [ID_W-1:0]  head_id,
  output logic [LEN_W-1:0] head_len
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ID_W-1:0]  id_mem  [DEPTH];
  logic [LEN_W-1:0] len_mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             do_push, do_pop;

  assign full     = (count == CNT_W'(DEPTH));
  assign empty    = (count == '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign head_id  = id_mem[rd_ptr];
  assign head_len = len_mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) begin
      id_mem[wr_ptr]  <= push_id;
      len_mem[wr_ptr] <= push_len;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end
endmodule

// File: rtl/axi_wmon_rd_tracker.sv
module axi_wmon_rd_tracker
  import axi_wmon_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ar_hs,
  input  logic [ID_W-1:0]  ar_id,
  input  logic [LEN_W-1:0] ar_len,
  input  logic             ar_excl,
  input  logic             r_hs,
  input  logic [ID_W-1:0]  r_id,
  input  logic             r_last,
  input  logic [1:0]       r_resp,
  input  logic             aw_hs,
  input  logic [ID_W-1:0]  aw_id,
  input  logic             aw_excl,
  output logic             ev_rlast,
  output logic             ev_excl,
  output logic             ev_ovf
);
  localparam int NID = 1 << ID_W;

  logic [NID-1:0]   pend, excl, fail;
  logic [LEN_W-1:0] r_len [NID];
  logic [LEN_W-1:0] r_cnt [NID];
  logic             r_act, r_final, r_close;

  assign r_act    = r_hs && pend[r_id];
  assign r_final  = (r_cnt[r_id] == r_len[r_id]);
  assign r_close  = r_act && (r_last || r_final);
  assign ev_rlast = r_act && (r_last != r_final);
  assign ev_ovf   = ar_hs && pend[ar_id];
  assign ev_excl  = aw_hs && aw_excl && fail[aw_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      excl <= '0;
      fail <= '0;
      for (int i = 0; i < NID; i++) begin
        r_len[i] <= '0;
        r_cnt[i] <= '0;
      end
    end else begin
      if (ar_hs && !pend[ar_id]) begin
        pend[ar_id]  <= 1'b1;
        excl[ar_id]  <= ar_excl;
        r_len[ar_id] <= ar_len;
        r_cnt[ar_id] <= '0;
      end
      if (ev_excl) fail[aw_id] <= 1'b0;
      if (r_act) begin
        if (r_close) begin
          pend[r_id]  <= 1'b0;
          r_cnt[r_id] <= '0;
          if (excl[r_id]) fail[r_id] <= (r_resp != RESP_EXOKAY);
        end else begin
          r_cnt[r_id] <= r_cnt[r_id] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/axi_wmon_err_pick.sv
module axi_wmon_err_pick #(
  parameter int NUM   = 17,
  parameter int IDX_W = 5
) (
  input  logic [NUM-1:0]   ev,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |ev;
    idx = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (ev[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/axi_wr_protocol_monitor.sv
module axi_wr_protocol_monitor
  import axi_wmon_pkg::*;
#(
  parameter int ID_W     = 4,
  parameter int LEN_W    = 4,
  parameter int AQ_DEPTH = 8,
  parameter int IL_DEPTH = 4,
  parameter int TIMEOUT  = 1024,
  parameter int CNT_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aw_valid,
  input  logic              aw_ready,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [LEN_W-1:0]  aw_len,
  input  logic              aw_excl,
  input  logic              w_valid,
  input  logic              w_ready,
  input  logic [ID_W-1:0]   w_id,
  input  logic              w_last,
  input  logic              b_valid,
  input  logic              b_ready,
  input  logic [ID_W-1:0]   b_id,
  input  logic              ar_valid,
  input  logic              ar_ready,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [LEN_W-1:0]  ar_len,
  input  logic              ar_excl,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic [ID_W-1:0]   r_id,
  input  logic              r_last,
  input  logic [1:0]        r_resp,
  output logic              err_valid,
  output logic [CODE_W-1:0] err_code
);
  localparam int NID    = 1 << ID_W;
  localparam int BEAT_W = LEN_W + 1;
  localparam int TO_W   = $clog2(TIMEOUT + 1);
  localparam int IDX_W  = $clog2(NUM_EV);

  logic aw_hs, w_hs, b_hs, ar_hs, r_hs;
  assign aw_hs = aw_valid && aw_ready;
  assign w_hs  = w_valid && w_ready;
  assign b_hs  = b_valid && b_ready;
  assign ar_hs = ar_valid && ar_ready;
  assign r_hs  = r_valid && r_ready;

  // address order queue
  logic             q_full, q_empty;
  logic [ID_W-1:0]  q_head_id;
  logic [LEN_W-1:0] q_head_len;
  logic             w_new, w_act;
  logic [LEN_W-1:0] cur_len;
  logic [BEAT_W-1:0] cur_k;

  axi_wmon_addr_queue #(.ID_W(ID_W), .LEN_W(LEN_W), .DEPTH(AQ_DEPTH)) u_aq (
    .clk(clk), .rst_n(rst_n),
    .push(aw_hs), .push_id(aw_id), .push_len(aw_len),
    .pop(w_new), .full(q_full), .empty(q_empty),
    .head_id(q_head_id), .head_len(q_head_len)
  );

  // read path and exclusive tracking
  logic rd_ev_rlast, rd_ev_excl, rd_ev_ovf;

  axi_wmon_rd_tracker #(.ID_W(ID_W), .LEN_W(LEN_W)) u_rd (
    .clk(clk), .rst_n(rst_n),
    .ar_hs(ar_hs), .ar_id(ar_id), .ar_len(ar_len), .ar_excl(ar_excl),
    .r_hs(r_hs), .r_id(r_id), .r_last(r_last), .r_resp(r_resp),
    .aw_hs(aw_hs), .aw_id(aw_id), .aw_excl(aw_excl),
    .ev_rlast(rd_ev_rlast), .ev_excl(rd_ev_excl), .ev_ovf(rd_ev_ovf)
  );

  // per-ID write tables
  logic [NID-1:0]    w_open;
  logic [LEN_W-1:0]  w_len    [NID];
  logic [BEAT_W-1:0] w_cnt    [NID];
  logic [CNT_W-1:0]  addr_cnt [NID];
  logic [CNT_W-1:0]  data_cnt [NID];
  logic [NID-1:0]    aw_inc_v, d_inc_v, b_dec_v;
  logic              b_ok;

  assign b_ok = b_hs && (addr_cnt[b_id] != '0) && (data_cnt[b_id] != '0);

  for (genvar g = 0; g < NID; g++) begin : g_dec
    assign aw_inc_v[g] = aw_hs && (aw_id == ID_W'(g));
    assign d_inc_v[g]  = w_act && w_last && (w_id == ID_W'(g));
    assign b_dec_v[g]  = b_ok && (b_id == ID_W'(g));
  end

  always_comb begin
    w_new   = 1'b0;
    w_act   = 1'b0;
    cur_len = '0;
    cur_k   = '0;
    if (w_hs) begin
      if (w_open[w_id]) begin
        w_act   = 1'b1;
        cur_len = w_len[w_id];
        cur_k   = w_cnt[w_id];
      end else if (!q_empty && (q_head_id == w_id)) begin
        w_act   = 1'b1;
        w_new   = 1'b1;
        cur_len = q_head_len;
      end
    end
  end

  // stall watchdog on open bursts
  logic [TO_W-1:0] idle_cnt;
  logic            w_idle, to_fire;
  assign w_idle  = (|w_open) && !w_hs;
  assign to_fire = w_idle && (idle_cnt == TO_W'(TIMEOUT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !w_idle || to_fire) idle_cnt <= '0;
    else                              idle_cnt <= idle_cnt + 1'b1;
  end

  // violation vector
  logic [NUM_EV-1:0] ev;
  always_comb begin
    ev = '0;
    if (!rst_n) begin
      ev[EV_RST_AW] = aw_valid;
      ev[EV_RST_W]  = w_valid;
      ev[EV_RST_B]  = b_valid;
      ev[EV_RST_AR] = ar_valid;
      ev[EV_RST_R]  = r_valid;
    end else begin
      ev[EV_ORDER] = w_hs && !w_act;
      if (w_act) begin
        if (cur_k > {1'b0, cur_len})                  ev[EV_OVERRUN]   = 1'b1;
        else if (cur_k == {1'b0, cur_len} && !w_last) ev[EV_NOLAST]    = 1'b1;
        else if (cur_k < {1'b0, cur_len} && w_last)   ev[EV_EARLYLAST] = 1'b1;
      end
      ev[EV_INTERLEAVE] = w_new && ($countones(w_open) >= IL_DEPTH);
      ev[EV_B_NOADDR]   = b_hs && (addr_cnt[b_id] == '0);
      ev[EV_B_NODATA]   = b_hs && (addr_cnt[b_id] != '0) && (data_cnt[b_id] == '0);
      ev[EV_RLAST]      = rd_ev_rlast;
      ev[EV_EXCL]       = rd_ev_excl;
      ev[EV_TIMEOUT]    = to_fire;
      ev[EV_OVERFLOW]   = (aw_hs && q_full) || rd_ev_ovf;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_open <= '0;
      for (int i = 0; i < NID; i++) begin
        w_len[i]    <= '0;
        w_cnt[i]    <= '0;
        addr_cnt[i] <= '0;
        data_cnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NID; i++) begin
        addr_cnt[i] <= addr_cnt[i] + CNT_W'(aw_inc_v[i]) - CNT_W'(b_dec_v[i]);
        data_cnt[i] <= data_cnt[i] + CNT_W'(d_inc_v[i]) - CNT_W'(b_dec_v[i]);
      end
      if (w_act) begin
        if (w_last) begin
          w_open[w_id] <= 1'b0;
          w_cnt[w_id]  <= '0;
        end else begin
          w_open[w_id] <= 1'b1;
          w_len[w_id]  <= cur_len;
          w_cnt[w_id]  <= (cur_k == {BEAT_W{1'b1}}) ? cur_k : cur_k + 1'b1;
        end
      end
    end
  end

  // lowest code wins, registered strobe
  logic             ev_any;
  logic [IDX_W-1:0] ev_idx;

  axi_wmon_err_pick #(.NUM(NUM_EV), .IDX_W(IDX_W)) u_pick (
    .ev(ev), .any(ev_any), .idx(ev_idx)
  );

  always_ff @(posedge clk) begin
    err_valid <= ev_any;
    err_code  <= CODE_W'(CODE_BASE) + CODE_W'(ev_idx);
  end
endmodule

// File: rtl/axi_wr_protocol_monitor_sva.sv
module axi_wr_protocol_monitor_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        aw_valid,
  input logic        w_valid,
  input logic        w_ready,
  input logic        b_valid,
  input logic        b_ready,
  input logic        ar_valid,
  input logic        r_valid,
  input logic        r_ready,
  input logic        err_valid,
  input logic [16:0] err_code
);
  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  // R13: only defined codes are ever emitted
  a_r13_code_known: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> (err_code >= 17'd60160 && err_code <= 17'd60176 && err_code != 17'd60163));

  // R8: write address valid during reset is reported with its code
  a_r8_aw_in_reset: assert property (@(posedge clk)
    (started && $past(!rst_n && aw_valid)) |-> (err_valid && err_code == 17'd60168));

  // R8: a quiet reset cycle produces no strobe
  a_r8_quiet_reset: assert property (@(posedge clk)
    (started && $past(!rst_n) && !$past(aw_valid || w_valid || b_valid || ar_valid || r_valid))
      |-> !err_valid);

  // R1: order violations follow an accepted write beat
  a_r1_order_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_code == 17'd60160) |-> $past(w_valid && w_ready));

  // R6 / R7: response violations follow an accepted response
  a_r6_resp_on_hs: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && (err_code == 17'd60166 || err_code == 17'd60167)) |-> $past(b_valid && b_ready));

  // R9: read last mismatches follow an accepted read beat
  a_r9_rlast_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_code == 17'd60173) |-> $past(r_valid && r_ready));

  // R11: a stall report never coincides with an accepted write beat
  a_r11_stall_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (err_valid && err_code == 17'd60175) |-> $past(!(w_valid && w_ready)));
endmodule

bind axi_wr_protocol_monitor axi_wr_protocol_monitor_sva u_sva (
  .clk(clk), .rst_n(rst_n), .aw_valid(aw_valid), .w_valid(w_valid), .w_ready(w_ready),
  .b_valid(b_valid), .b_ready(b_ready), .ar_valid(ar_valid), .r_valid(r_valid),
  .r_ready(r_ready), .err_valid(err_valid), .err_code(err_code)
);

// File: tb/axi_wr_protocol_monitor_tb_top.sv
module axi_wr_protocol_monitor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 4, LEN_W = 4, AQ_DEPTH = 4, IL_DEPTH = 2, TIMEOUT = 16, CNT_W = 4;
  localparam int BASE = 60160;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rst_n = 1'b0;
  logic aw_valid = 0, aw_ready = 0, aw_excl = 0;
  logic [ID_W-1:0] aw_id = '0;
  logic [LEN_W-1:0] aw_len = '0;
  logic w_valid = 0, w_ready = 0, w_last = 0;
  logic [ID_W-1:0] w_id = '0;
  logic b_valid = 0, b_ready = 0;
  logic [ID_W-1:0] b_id = '0;
  logic ar_valid = 0, ar_ready = 0, ar_excl = 0;
  logic [ID_W-1:0] ar_id = '0;
  logic [LEN_W-1:0] ar_len = '0;
  logic r_valid = 0, r_ready = 0, r_last = 0;
  logic [ID_W-1:0] r_id = '0;
  logic [1:0] r_resp = 2'b00;
  logic err_valid;
  logic [16:0] err_code;

  axi_wr_protocol_monitor #(.ID_W(ID_W), .LEN_W(LEN_W), .AQ_DEPTH(AQ_DEPTH),
    .IL_DEPTH(IL_DEPTH), .TIMEOUT(TIMEOUT), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_id(aw_id), .aw_len(aw_len), .aw_excl(aw_excl),
    .w_valid(w_valid), .w_ready(w_ready), .w_id(w_id), .w_last(w_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_id(ar_id), .ar_len(ar_len), .ar_excl(ar_excl),
    .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_last(r_last), .r_resp(r_resp),
    .err_valid(err_valid), .err_code(err_code)
  );

  int checks = 0, errors = 0, pulses = 0;
  logic [16:0] seen = '0;
  bit done = 0;

  always @(negedge clk) begin
    if (err_valid === 1'b1) begin
      pulses++;
      if (err_code >= 17'(BASE) && err_code <= 17'(BASE + 16)) seen[err_code - 17'(BASE)] = 1'b1;
    end
  end

  function automatic logic [16:0] m(input int code);
    return 17'(1) << (code - BASE);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic clr();
    seen = '0;
    pulses = 0;
  endtask

  task automatic expect_seen(input logic [16:0] exp, input string tag);
    chk(seen == exp, tag, int'(seen), int'(exp));
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step(); rst_n = 1; step(); clr();
  endtask

  task automatic aw_x(input int id, input int len, input bit ex);
    aw_valid = 1; aw_ready = 1; aw_id = ID_W'(id); aw_len = LEN_W'(len); aw_excl = ex;
    step(); aw_valid = 0; aw_ready = 0; aw_excl = 0;
  endtask

  task automatic w_x(input int id, input bit last, input bit rdy);
    w_valid = 1; w_ready = rdy; w_id = ID_W'(id); w_last = last;
    step(); w_valid = 0; w_ready = 0; w_last = 0;
  endtask

  task automatic b_x(input int id);
    b_valid = 1; b_ready = 1; b_id = ID_W'(id);
    step(); b_valid = 0; b_ready = 0;
  endtask

  task automatic ar_x(input int id, input int len, input bit ex);
    ar_valid = 1; ar_ready = 1; ar_id = ID_W'(id); ar_len = LEN_W'(len); ar_excl = ex;
    step(); ar_valid = 0; ar_ready = 0; ar_excl = 0;
  endtask

  task automatic r_x(input int id, input bit last, input logic [1:0] resp);
    r_valid = 1; r_ready = 1; r_id = ID_W'(id); r_last = last; r_resp = resp;
    step(); r_valid = 0; r_ready = 0; r_last = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic t_reset();
    rst_n = 0; step(); step();
    chk(err_valid == 1'b0, "R8 quiet reset strobe", int'(err_valid), 0);
    for (int k = 0; k < 5; k++) begin
      clr();
      case (k)
        0: aw_valid = 1;
        1: w_valid = 1;
        2: b_valid = 1;
        3: ar_valid = 1;
        default: r_valid = 1;
      endcase
      step();
      aw_valid = 0; w_valid = 0; b_valid = 0; ar_valid = 0; r_valid = 0;
      step();
      expect_seen(m(60168 + k), "R8 valid in reset");
    end
    clr();
    w_valid = 1; r_valid = 1; step(); w_valid = 0; r_valid = 0; step();
    expect_seen(m(60169), "R13 lowest code wins");
    chk(pulses == 1, "R13 single pulse", pulses, 1);
    rst_n = 1; step(); clr();
    aw_x(3, 0, 0);
    rst_n = 0; step(); step(); rst_n = 1; step(); clr();
    b_x(3);
    expect_seen(m(60166), "R8 tables cleared");
  endtask

  task automatic t_clean();
    do_reset();
    aw_x(1, 2, 0);
    w_x(1, 0, 1); w_x(1, 0, 0); w_x(1, 0, 1); w_x(1, 1, 1);
    b_x(1);
    idle(1);
    expect_seen('0, "R1 clean burst with stalled beat");
  endtask

  task automatic t_order();
    do_reset();
    aw_x(2, 0, 0); aw_x(3, 0, 0);
    w_x(3, 1, 1);
    expect_seen(m(60160), "R1 first data out of order");
  endtask

  task automatic t_len();
    do_reset();
    aw_x(1, 1, 0); w_x(1, 0, 1); clr();
    w_x(1, 0, 1);
    expect_seen(m(60162), "R3 final beat without last");
    clr();
    w_x(1, 1, 1);
    expect_seen(m(60161), "R2 beat beyond length");
  endtask

  task automatic t_early();
    do_reset();
    aw_x(1, 2, 0);
    w_x(1, 1, 1);
    expect_seen(m(60164), "R4 early last");
  endtask

  task automatic t_interleave();
    do_reset();
    aw_x(1, 1, 0); aw_x(2, 1, 0); aw_x(3, 1, 0);
    w_x(1, 0, 1); w_x(2, 0, 1);
    expect_seen('0, "R5 within depth");
    w_x(3, 0, 1);
    expect_seen(m(60165), "R5 depth exceeded");
  endtask

  task automatic t_bresp();
    do_reset();
    b_x(5);
    chk(err_valid == 1'b1 && err_code == 17'd60166, "R6 response without address",
        int'(err_code), 60166);
    step();
    chk(err_valid == 1'b0, "R13 strobe lasts one cycle", int'(err_valid), 0);
    aw_x(5, 0, 0); clr();
    b_x(5);
    expect_seen(m(60167), "R7 response without data");
    w_x(5, 1, 1); clr();
    b_x(5);
    expect_seen('0, "R7 response after data");
  endtask

  task automatic t_rlast();
    do_reset();
    ar_x(2, 1, 0); r_x(2, 0, 2'b00);
    expect_seen('0, "R9 first read beat");
    r_x(2, 0, 2'b00);
    expect_seen(m(60173), "R9 missing rlast");
    ar_x(3, 1, 0); clr();
    r_x(3, 1, 2'b00);
    expect_seen(m(60173), "R9 early rlast");
    ar_x(4, 1, 0); clr();
    r_x(4, 0, 2'b00); r_x(4, 1, 2'b00);
    expect_seen('0, "R9 correct read burst");
  endtask

  task automatic t_excl();
    do_reset();
    ar_x(6, 0, 1); r_x(6, 1, 2'b00); clr();
    aw_x(6, 0, 1);
    expect_seen(m(60174), "R10 exclusive write after failed read");
    ar_x(7, 0, 1); r_x(7, 1, 2'b01); clr();
    aw_x(7, 0, 1);
    expect_seen('0, "R10 exclusive write after exokay");
    ar_x(9, 0, 1); r_x(9, 1, 2'b10); clr();
    aw_x(9, 0, 0);
    expect_seen('0, "R10 plain write after failed read");
  endtask

  task automatic t_timeout();
    do_reset();
    aw_x(1, 3, 0); w_x(1, 0, 1); clr();
    idle(TIMEOUT - 1);
    expect_seen('0, "R11 one cycle short of timeout");
    idle(1);
    expect_seen(m(60175), "R11 timeout reached");
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 1; i <= AQ_DEPTH; i++) aw_x(i, 0, 0);
    expect_seen('0, "R12 queue filled");
    aw_x(AQ_DEPTH + 1, 0, 0);
    expect_seen(m(60176), "R12 address queue overflow");
    ar_x(2, 1, 0); clr();
    ar_x(2, 0, 0);
    expect_seen(m(60176), "R12 read tracking overflow");
  endtask

  initial begin
    t_reset();
    t_clean();
    t_order();
    t_len();
    t_early();
    t_interleave();
    t_bresp();
    t_rlast();
    t_excl();
    t_timeout();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule